// File: doc/BRIEF.md
# Reconfigurable ALU Array

This block is a small grid of simple arithmetic and logic units that runs one custom operation at a time. A wide configuration word sets up the whole grid. For every unit it gives the operation, the two operand selects and an optional immediate. It also maps unit outputs onto eight result lanes and gives the number of rows the operation uses. Eight 32-bit register operands feed the grid.

The grid has five chained rows holding six, four, three, two and one units, sixteen units in all. The first row picks its operands from the eight inputs. Every later row picks only from the outputs of the row just above it. A unit set to pass its first operand through unchanged moves a value down the grid.

A one-cycle `start` pulse hands over an operation. The block registers the configuration word and the operands on that edge. It then counts down a latency taken from the configured depth. When the count ends, it loads the result lanes and raises `done` for one cycle.

Top module: `rfu_array`

## Requirements
- R1: While `rstN` is low, `done`, `results` and `resultValid` are all zero.
- R2: The 4-bit operation code acts on operands A and B as follows: 0 passes A; 1 gives A+B; 2 gives A-B; 3 gives A AND B; 4 gives A OR B; 5 gives A XOR B; 6 gives NOT (A OR B); 7 gives 1 when A is less than B as signed numbers and 0 otherwise; 8 shifts A left by B[4:0]; 9 shifts A right logically by B[4:0]. Codes 10 to 15 give 0. All data is 32 bits wide.
- R3: Unit n (0..15) owns configuration bits [n*43 +: 43]. Within that field, bits [3:0] hold the operation, [6:4] the A select, [9:7] the B select, bit 10 makes the immediate replace B, and [42:11] hold the immediate. Units are numbered row by row: row 0 holds units 0-5, row 1 holds 6-9, row 2 holds 10-12, row 3 holds 13-14 and row 4 holds unit 15.
- R4: A select or B select in row 0 picks operand k, found at `operands[k*32 +: 32]`. In later rows it picks the k-th unit of the row above. A select value at or beyond that row's width yields 0.
- R5: Result lane l (0..7) is set by configuration bits [688+l*5 +: 5]. Bits [3:0] name the unit and bit 4 is the lane's valid flag. A lane whose valid flag is clear returns 0.
- R6: The depth field is `cfgWord[730:728]`. It is clamped to the range 1..5, giving d, and the latency is L = d/2+1 cycles using integer division. `done` goes high on the L-th rising edge after the edge that accepted `start`, and stays high for exactly one cycle.
- R7: `results` and `resultValid` change only on the edge that raises `done`. At all other times they hold their values.
- R8: While an operation is in flight, `start` is ignored.
- R9: The configuration and operands are taken on the accepting edge. Later changes to `cfgWord` or `operands` do not affect the operation in flight.
- R10: A `start` that is high in the same cycle as `done` is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Starts an operation when the block is idle |
| cfgWord | input | 731 | Unit fields, lane routing and depth field |
| operands | input | 256 | Eight 32-bit register operands, operand k at [k*32 +: 32] |
| results | output | 256 | Eight 32-bit result lanes, lane l at [l*32 +: 32] |
| resultValid | output | 8 | Valid flag of each lane, as configured |
| done | output | 1 | One-cycle completion pulse |

## Verification
Completing an operation and accepting the next one can happen in the same cycle. A `start` that arrives while `done` is high must be taken, while one cycle earlier it must be dropped. The bench provokes this in two ways. It raises `start` in the cycle where `done` is seen. It also holds `start` high through a long burst in which the configuration changes every cycle, so that the block both drops and accepts requests. A behavioural model keeps its own countdown and captured copies of the configuration and operands. The bench compares `done`, every result lane and every valid flag with this model on every clock. A start that was wrongly accepted, or one that was wrongly dropped, shows up either as a mismatch in timing or as the wrong lane data.

// File: rtl/rfu_pkg.sv
package rfu_pkg;
  localparam int DW     = 32;
  localparam int NIN    = 8;
  localparam int NOUT   = 8;
  localparam int NROWS  = 5;
  localparam int ROWW [NROWS] = '{6, 4, 3, 2, 1};

  function automatic int rowBase(int r);
    int s = 0;
    for (int i = 0; i < r; i++) s += ROWW[i];
    return s;
  endfunction

  localparam int NODES   = rowBase(NROWS);
  localparam int OPW     = 4;
  localparam int SELW    = $clog2(NIN);
  localparam int SHW     = $clog2(DW);
  localparam int NSELW   = $clog2(NODES);
  localparam int FUW     = OPW + 2 * SELW + 1 + DW;
  localparam int OUTW    = NSELW + 1;
  localparam int DEPW    = 3;
  localparam int OUTBASE = NODES * FUW;
  localparam int DEPBASE = OUTBASE + NOUT * OUTW;
  localparam int CFGW    = DEPBASE + DEPW;
  localparam int MAXLAT  = NROWS / 2 + 1;
  localparam int CNTW    = $clog2(MAXLAT + 1);

  typedef enum logic [OPW-1:0] {
    OP_MOV = 4'd0, OP_ADD = 4'd1, OP_SUB = 4'd2, OP_AND = 4'd3, OP_OR = 4'd4,
    OP_XOR = 4'd5, OP_NOR = 4'd6, OP_SLT = 4'd7, OP_SLL = 4'd8, OP_SRL = 4'd9
  } fuOp_e;

  typedef struct packed {
    logic capture;
    logic commit;
  } strobe_t;

  function automatic logic [DW-1:0] fuEval(logic [OPW-1:0] op, logic [DW-1:0] a, logic [DW-1:0] b);
    case (op)
      OP_MOV:  return a;
      OP_ADD:  return a + b;
      OP_SUB:  return a - b;
      OP_AND:  return a & b;
      OP_OR:   return a | b;
      OP_XOR:  return a ^ b;
      OP_NOR:  return ~(a | b);
      OP_SLT:  return {{(DW-1){1'b0}}, ($signed(a) < $signed(b))};
      OP_SLL:  return a << b[SHW-1:0];
      OP_SRL:  return a >> b[SHW-1:0];
      default: return '0;
    endcase
  endfunction

  function automatic int prevWidth(int r);
    if (r == 0) return NIN;
    return ROWW[r-1];
  endfunction
endpackage

// File: rtl/rfu_ctrl.sv
module rfu_ctrl
  import rfu_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [DEPW-1:0] depthIn,
  output strobe_t         stb,
  output logic            done
);
  logic [CNTW-1:0] cnt;
  logic            busy;
  logic            accept;

  function automatic logic [CNTW-1:0] latOf(logic [DEPW-1:0] d);
    int dd = int'(d);
    if (dd < 1) dd = 1;
    if (dd > NROWS) dd = NROWS;
    return CNTW'(dd / 2 + 1);
  endfunction

  assign busy        = (cnt != '0);
  assign accept      = start && !busy;
  assign stb.capture = accept;
  assign stb.commit  = (cnt == CNTW'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= stb.commit;
      if (accept)    cnt <= latOf(depthIn);
      else if (busy) cnt <= cnt - CNTW'(1);
    end
  end

  a_r6_done_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r6_no_early_done: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> !done);
  a_r6_depth_one_latency: assert property (@(posedge clk) disable iff (!rstN)
    (accept && depthIn <= DEPW'(1)) |=> ##1 done);
  a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> (cnt == $past(cnt) - CNTW'(1)));
endmodule

// File: rtl/rfu_datapath.sv
module rfu_datapath
  import rfu_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             stb,
  input  logic [CFGW-1:0]     cfgIn,
  input  logic [NIN*DW-1:0]   opIn,
  output logic [NOUT*DW-1:0]  resOut,
  output logic [NOUT-1:0]     resValid
);
  logic [CFGW-1:0]     cfgQ;
  logic [NIN*DW-1:0]   opQ;
  logic [NODES*DW-1:0] allNodes;
  logic [NOUT*DW-1:0]  laneNext;
  logic [NOUT-1:0]     laneVld;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ <= '0;
      opQ  <= '0;
    end else if (stb.capture) begin
      cfgQ <= cfgIn;
      opQ  <= opIn;
    end
  end

  for (genvar r = 0; r < NROWS; r++) begin : g_row
    localparam int W    = ROWW[r];
    localparam int BASE = rowBase(r);
    localparam int PW   = prevWidth(r);
    logic [PW*DW-1:0]  src;
    logic [NIN*DW-1:0] srcPad;
    logic [W*DW-1:0]   rowOut;

    if (r == 0) begin : g_in
      assign src = opQ;
    end else begin : g_chain
      assign src = g_row[r-1].rowOut;
    end
    // zero-extension makes out-of-range selects read 0
    assign srcPad = (NIN*DW)'(src);

    for (genvar f = 0; f < W; f++) begin : g_fu
      localparam int N = BASE + f;
      logic [FUW-1:0]  fld;
      logic [OPW-1:0]  op;
      logic [SELW-1:0] selA, selB;
      logic            useImm;
      logic [DW-1:0]   imm, a, b;

      assign fld    = cfgQ[N*FUW +: FUW];
      assign op     = fld[OPW-1:0];
      assign selA   = fld[OPW +: SELW];
      assign selB   = fld[OPW+SELW +: SELW];
      assign useImm = fld[OPW+2*SELW];
      assign imm    = fld[FUW-1 -: DW];
      assign a      = srcPad[selA*DW +: DW];
      assign b      = useImm ? imm : srcPad[selB*DW +: DW];
      assign rowOut[f*DW +: DW] = fuEval(op, a, b);
    end

    assign allNodes[BASE*DW +: W*DW] = rowOut;
  end

  for (genvar l = 0; l < NOUT; l++) begin : g_lane
    logic [NSELW-1:0] nodeSel;
    assign nodeSel = cfgQ[OUTBASE + l*OUTW +: NSELW];
    assign laneVld[l] = cfgQ[OUTBASE + l*OUTW + NSELW];
    assign laneNext[l*DW +: DW] = laneVld[l] ? allNodes[nodeSel*DW +: DW] : '0;

    a_r5_invalid_lane_zero: assert property (@(posedge clk) disable iff (!rstN)
      !resValid[l] |-> (resOut[l*DW +: DW] == '0));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resOut   <= '0;
      resValid <= '0;
    end else if (stb.commit) begin
      resOut   <= laneNext;
      resValid <= laneVld;
    end
  end

  a_r7_results_hold: assert property (@(posedge clk) disable iff (!rstN)
    !stb.commit |=> ($stable(resOut) && $stable(resValid)));
  a_r9_capture_hold: assert property (@(posedge clk) disable iff (!rstN)
    !stb.capture |=> ($stable(cfgQ) && $stable(opQ)));
endmodule

// File: rtl/rfu_array.sv
module rfu_array
  import rfu_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [CFGW-1:0]    cfgWord,
  input  logic [NIN*DW-1:0]  operands,
  output logic [NOUT*DW-1:0] results,
  output logic [NOUT-1:0]    resultValid,
  output logic               done
);
  strobe_t stb;

  rfu_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .depthIn (cfgWord[DEPBASE +: DEPW]),
    .stb     (stb),
    .done    (done)
  );

  rfu_datapath i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .cfgIn    (cfgWord),
    .opIn     (operands),
    .resOut   (results),
    .resValid (resultValid)
  );
endmodule

// File: tb/test_rfu_array.sv
module test_rfu_array;
  import rfu_pkg::*;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic [CFGW-1:0]    cfgWord  = '0;
  logic [NIN*DW-1:0]  operands = '0;
  logic [NOUT*DW-1:0] results;
  logic [NOUT-1:0]    resultValid;
  logic               done;
  int nCmp = 0, nBad = 0;
  bit finished = 0;

  rfu_array i_rfu_array (.clk(clk), .rstN(rstN), .start(start), .cfgWord(cfgWord),
    .operands(operands), .results(results), .resultValid(resultValid), .done(done));

  always #10ns clk = ~clk;

  // ---------------- behavioural reference ----------------
  function automatic int latOf(logic [CFGW-1:0] c);
    int d = int'(c[DEPBASE +: DEPW]);
    if (d < 1) d = 1;
    if (d > 5) d = 5;
    return d / 2 + 1;
  endfunction

  function automatic void compute(input logic [CFGW-1:0] c, input logic [NIN*DW-1:0] o,
                                  output logic [NOUT*DW-1:0] r, output logic [NOUT-1:0] v);
    logic [31:0] nv [16];
    int wid [5] = '{6, 4, 3, 2, 1};
    int base = 0;
    for (int row = 0; row < 5; row++) begin
      int pw = (row == 0) ? 8 : wid[row-1];
      int pb = (row == 0) ? 0 : base - wid[row-1];
      for (int f = 0; f < wid[row]; f++) begin
        int n = base + f;
        logic [42:0] fl = c[n*43 +: 43];
        int sa = int'(fl[6:4]);
        int sb = int'(fl[9:7]);
        logic [31:0] a, b;
        if (row == 0) begin a = o[sa*32 +: 32]; b = o[sb*32 +: 32]; end
        else begin
          a = (sa < pw) ? nv[pb+sa] : 32'd0;
          b = (sb < pw) ? nv[pb+sb] : 32'd0;
        end
        if (fl[10]) b = fl[42:11];
        case (int'(fl[3:0]))
          0: nv[n] = a;
          1: nv[n] = a + b;
          2: nv[n] = a - b;
          3: nv[n] = a & b;
          4: nv[n] = a | b;
          5: nv[n] = a ^ b;
          6: nv[n] = ~(a | b);
          7: nv[n] = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
          8: nv[n] = a << b[4:0];
          9: nv[n] = a >> b[4:0];
          default: nv[n] = 32'd0;
        endcase
      end
      base += wid[row];
    end
    for (int l = 0; l < 8; l++) begin
      logic [4:0] lf = c[688 + l*5 +: 5];
      v[l] = lf[4];
      r[l*32 +: 32] = lf[4] ? nv[int'(lf[3:0])] : 32'd0;
    end
  endfunction

  logic [CFGW-1:0]    mCfg;
  logic [NIN*DW-1:0]  mOps;
  logic [NOUT*DW-1:0] mRes;
  logic [NOUT-1:0]    mVal;
  logic               mDone;
  int                 mCnt;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCnt <= 0; mDone <= 1'b0; mRes <= '0; mVal <= '0; mCfg <= '0; mOps <= '0;
    end else begin
      mDone <= 1'b0;
      if (mCnt == 0) begin
        if (start) begin mCfg <= cfgWord; mOps <= operands; mCnt <= latOf(cfgWord); end
      end else begin
        mCnt <= mCnt - 1;
        if (mCnt == 1) begin
          logic [NOUT*DW-1:0] r; logic [NOUT-1:0] v;
          compute(mCfg, mOps, r, v);
          mRes <= r; mVal <= v; mDone <= 1'b1;
        end
      end
    end
  end

  task automatic chk(string tag, logic [NOUT*DW-1:0] act, logic [NOUT*DW-1:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!finished) begin
      if (!rstN) begin
        chk("R1 reset done",  {255'd0, done}, '0);
        chk("R1 reset lanes", results, '0);
        chk("R1 reset valid", {248'd0, resultValid}, '0);
      end else begin
        chk("R6 done timing", {255'd0, done}, {255'd0, mDone});
        chk("R7 result lanes", results, mRes);
        chk("R5 valid flags", {248'd0, resultValid}, {248'd0, mVal});
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  function automatic logic [CFGW-1:0] withFu(logic [CFGW-1:0] c, int n, int op, int sa, int sb,
                                             bit ui, logic [31:0] imm);
    c[n*43 +: 43] = {imm, ui, 3'(sb), 3'(sa), 4'(op)};
    return c;
  endfunction
  function automatic logic [CFGW-1:0] withLane(logic [CFGW-1:0] c, int l, int node, bit v);
    c[688 + l*5 +: 5] = {v, 4'(node)};
    return c;
  endfunction
  function automatic logic [CFGW-1:0] rndCfg();
    logic [CFGW-1:0] c;
    for (int i = 0; i < CFGW; i++) c[i] = 1'($urandom);
    return c;
  endfunction
  function automatic logic [NIN*DW-1:0] rndOps();
    logic [NIN*DW-1:0] o;
    for (int i = 0; i < NIN; i++) o[i*32 +: 32] = $urandom;
    return o;
  endfunction

  task automatic runOp(logic [CFGW-1:0] c, logic [NIN*DW-1:0] o, output int cyc);
    cfgWord = c; operands = o; start = 1'b1; cyc = 0;
    do begin @(negedge clk); cyc++; start = 1'b0; end while (!done && cyc < 20);
  endtask

  logic [CFGW-1:0]    cfgA, cfgB;
  logic [NIN*DW-1:0]  opsA;
  logic [NOUT*DW-1:0] expA;

  initial begin
    int cyc;
    // directed configuration A, depth 2 => L = 2
    cfgA = '0;
    cfgA = withFu(cfgA, 0, 1, 0, 1, 0, 0);        // ADD
    cfgA = withFu(cfgA, 1, 2, 0, 1, 0, 0);        // SUB
    cfgA = withFu(cfgA, 2, 7, 1, 0, 0, 0);        // SLT signed
    cfgA = withFu(cfgA, 3, 5, 2, 3, 0, 0);        // XOR
    cfgA = withFu(cfgA, 4, 6, 2, 3, 0, 0);        // NOR
    cfgA = withFu(cfgA, 5, 8, 4, 0, 1, 32'd33);   // SLL by low 5 bits of 33
    cfgA = withFu(cfgA, 6, 9, 3, 0, 1, 32'd4);    // SRL
    cfgA = withFu(cfgA, 7, 4, 3, 4, 0, 0);        // OR
    cfgA = withFu(cfgA, 8, 0, 5, 0, 0, 0);        // MOVE
    cfgA = withFu(cfgA, 9, 0, 7, 0, 0, 0);        // MOVE from out-of-range select
    cfgA = withLane(cfgA, 0, 0, 1); cfgA = withLane(cfgA, 1, 1, 1);
    cfgA = withLane(cfgA, 2, 2, 1); cfgA = withLane(cfgA, 3, 4, 1);
    cfgA = withLane(cfgA, 4, 6, 1); cfgA = withLane(cfgA, 5, 7, 1);
    cfgA = withLane(cfgA, 6, 8, 1); cfgA = withLane(cfgA, 7, 9, 1);
    cfgA[DEPBASE +: DEPW] = 3'd2;
    opsA = {32'hDEADBEEF, 32'd0, 32'd0, 32'd1, 32'h00FF00FF, 32'h0F0F0000, 32'hFFFFFFFD, 32'd5};
    expA = {32'd0, 32'd2, 32'hFFF0FFFF, 32'h00FF000F, 32'hF000FF00, 32'd1, 32'd8, 32'd2};
    // directed configuration B: pass operand 7 down all five rows, depth 5 => L = 3
    cfgB = '0;
    cfgB = withFu(cfgB, 0, 0, 7, 0, 0, 0);
    cfgB = withLane(cfgB, 0, 15, 1);
    cfgB = withLane(cfgB, 3, 0, 0);
    cfgB[DEPBASE +: DEPW] = 3'd5;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R2 R3 R4: operation codes, field layout, selects
    runOp(cfgA, opsA, cyc);
    chk("R6 latency depth2", 256'(cyc), 256'd3);
    chk("R2 R3 R4 lanes", results, expA);
    chk("R5 valid all", {248'd0, resultValid}, {248'd0, 8'hFF});
    @(negedge clk);
    chk("R6 done single cycle", {255'd0, done}, '0);
    chk("R7 hold after done", results, expA);

    // R8 R9: ignored start and operand change while busy
    cfgWord = cfgB; operands = opsA; start = 1'b1;
    @(negedge clk);
    cfgWord = cfgA; operands = '1;
    @(negedge clk);
    start = 1'b0; cfgWord = rndCfg(); operands = rndOps();
    @(negedge clk);
    chk("R6 not done yet", {255'd0, done}, '0);
    @(negedge clk);
    chk("R6 depth5 done", {255'd0, done}, {255'd0, 1'b1});
    chk("R8 R9 lane data", results, {224'd0, 32'hDEADBEEF});
    chk("R5 invalid lanes", {248'd0, resultValid}, {248'd0, 8'h01});

    // R10: start in the done cycle
    runOp(cfgA, opsA, cyc);
    chk("R10 accepted on done", 256'(cyc), 256'd3);
    chk("R10 results", results, expA);

    // R6: depth clamping
    cfgB = rndCfg(); cfgB[DEPBASE +: DEPW] = 3'd0;
    @(negedge clk);
    runOp(cfgB, rndOps(), cyc);
    chk("R6 depth0 clamp", 256'(cyc), 256'd2);
    cfgB[DEPBASE +: DEPW] = 3'd7;
    @(negedge clk);
    runOp(cfgB, rndOps(), cyc);
    chk("R6 depth7 clamp", 256'(cyc), 256'd4);

    // random operations with random gaps
    for (int k = 0; k < 300; k++) begin
      runOp(rndCfg(), rndOps(), cyc);
      if (($urandom % 3) != 0) repeat ($urandom % 3) @(negedge clk);
    end
    // burst: start held high, inputs change every cycle
    start = 1'b1;
    for (int k = 0; k < 400; k++) begin
      cfgWord = rndCfg(); operands = rndOps();
      @(negedge clk);
    end
    start = 1'b0;
    repeat (6) @(negedge clk);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nCmp++; nBad++;
      $display("FAIL R6 watchdog act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end
endmodule